// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address front end of a synchronous burst memory. On a rising clock edge it captures an external word address when a burst is started, either from the processor-side strobe (gated by chip enable) or from the controller-side strobe. On later edges where the advance input is high, it steps through the remaining beats of a four-beat burst on its own.

The two low address bits follow one of two orders. Interleaved order XORs the start bits with the beat count. Linear order adds the beat count to the start bits, modulo four. The upper bits stay fixed for the whole burst. Bursting is optional: a new address can be loaded on every cycle, and each load takes effect at once. The output is the current internal word address. It is driven straight from registers, so it is valid just after the edge that updated it.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and the order is interleaved.
- R2: A rising edge with cpu_strobe_i=1 and chip_en_i=1 loads addr_i, and addr_o equals that address right after the edge.
- R3: cpu_strobe_i with chip_en_i=0 is ignored: if ctl_strobe_i and adv_i are also low, addr_o keeps its value.
- R4: ctl_strobe_i=1 loads addr_i whatever the value of chip_en_i. When both strobes would load, the processor-side strobe is taken.
- R5: When lin_mode_i was 0 at the burst start, each advance sets addr_o[1:0] = start[1:0] XOR beat count. For example, a start of 1 gives 1,0,3,2.
- R6: When lin_mode_i was 1 at the burst start, each advance sets addr_o[1:0] = (start[1:0] + beat count) mod 4.
- R7: The beat count wraps. After four advances, addr_o is back at the start address.
- R8: addr_o[ADDR_W-1:2] does not change on any edge that loads nothing.
- R9: With no valid strobe and adv_i=0, addr_o holds its value.
- R10: Loads on consecutive edges each take effect, with no idle cycle between them.
- R11: lin_mode_i is captured only at a burst start. Changing it during a burst has no effect on the following beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_strobe_i | input | 1 | Processor-side burst start |
| ctl_strobe_i | input | 1 | Controller-side burst start |
| chip_en_i | input | 1 | Chip enable, gates cpu_strobe_i |
| adv_i | input | 1 | Step to the next beat |
| lin_mode_i | input | 1 | 1 = linear order, 0 = interleaved |
| addr_i | input | ADDR_W | External word address |
| addr_o | output | ADDR_W | Current internal word address |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. Loads, steps and holds all appear on addr_o right after that edge, with no extra pipeline stage. The bench changes its inputs on the falling edge and lets the reference model update at the rising edge. It then compares addr_o a quarter period later, so each comparison falls in the cycle where the result is due. Mid-burst mode changes, disabled processor strobes and runs of four or more advances are compared over the same one-edge window as the plain loads.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_ADD = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } act_e;
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
  import burst_seq_pkg::*;
(
  input  logic cpu_strobe_i,
  input  logic ctl_strobe_i,
  input  logic chip_en_i,
  input  logic adv_i,
  output act_e act_o,
  output logic from_cpu_o
);
  logic cpu_ok;
  assign cpu_ok = cpu_strobe_i & chip_en_i;

  // processor-side strobe wins when both would load
  always_comb begin
    from_cpu_o = 1'b0;
    if (cpu_ok) begin
      act_o      = ACT_LOAD;
      from_cpu_o = 1'b1;
    end else if (ctl_strobe_i) begin
      act_o = ACT_LOAD;
    end else if (adv_i) begin
      act_o = ACT_STEP;
    end else begin
      act_o = ACT_HOLD;
    end
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  act_e              act_i,
  output logic [BEAT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else begin
      unique case (act_i)
        ACT_LOAD: cnt_o <= '0;
        ACT_STEP: cnt_o <= cnt_o + 1'b1;
        default:  cnt_o <= cnt_o;
      endcase
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] cnt_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] add_low;
  logic [BEAT_W-1:0] xor_low;

  // per-bit XOR map; add map wraps naturally at BEAT_W bits
  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_low[b] = start_i[b] ^ cnt_i[b];
  end
  assign add_low = start_i + cnt_i;

  assign low_o = (order_i == ORD_ADD) ? add_low : xor_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_strobe_i,
  input  logic              ctl_strobe_i,
  input  logic              chip_en_i,
  input  logic              adv_i,
  input  logic              lin_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  act_e              act;
  logic              from_cpu;
  logic [BEAT_W-1:0] cnt;
  logic [BEAT_W-1:0] start_q;
  logic [UP_W-1:0]   upper_q;
  order_e            order_q;
  logic [BEAT_W-1:0] low;

  burst_cmd_dec u_dec (
    .cpu_strobe_i (cpu_strobe_i),
    .ctl_strobe_i (ctl_strobe_i),
    .chip_en_i    (chip_en_i),
    .adv_i        (adv_i),
    .act_o        (act),
    .from_cpu_o   (from_cpu)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      upper_q <= '0;
      order_q <= ORD_XOR;
    end else if (act == ACT_LOAD) begin
      start_q <= addr_i[BEAT_W-1:0];
      upper_q <= addr_i[ADDR_W-1:BEAT_W];
      order_q <= lin_mode_i ? ORD_ADD : ORD_XOR;
    end
  end

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i (start_q),
    .cnt_i   (cnt),
    .order_i (order_q),
    .low_o   (low)
  );

  assign addr_o = {upper_q, low};

  logic unused_src;
  assign unused_src = from_cpu;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_strobe_i,
  input logic              ctl_strobe_i,
  input logic              chip_en_i,
  input logic              adv_i,
  input logic              lin_mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic ld;
  assign ld = (cpu_strobe_i & chip_en_i) | ctl_strobe_i;

  // R2
  p_cpu_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_strobe_i && chip_en_i) |=> addr_o == $past(addr_i));

  // R4
  p_ctl_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_strobe_i |=> addr_o == $past(addr_i));

  // R8
  p_upper_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R9, R3
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && !adv_i) |=> $stable(addr_o));

  // R5, R6
  p_step_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && adv_i) |=> addr_o != $past(addr_o));

  // R1
  always_comb begin
    if (!rst_ni) a_reset_r1: assert (addr_o == '0);
  end

  logic unused_mode;
  assign unused_mode = lin_mode_i;
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_strobe_i (cpu_strobe_i),
  .ctl_strobe_i (ctl_strobe_i),
  .chip_en_i    (chip_en_i),
  .adv_i        (adv_i),
  .lin_mode_i   (lin_mode_i),
  .addr_i       (addr_i),
  .addr_o       (addr_o)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int ADDR_W = 20;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cpu_strobe_i = 1'b0;
  logic              ctl_strobe_i = 1'b0;
  logic              chip_en_i = 1'b0;
  logic              adv_i = 1'b0;
  logic              lin_mode_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  // reference state
  int m_up = 0, m_st = 0, m_cnt = 0, m_lin = 0;

  always #10 clk_i = ~clk_i;

  burst_addr_seq #(.ADDR_W(ADDR_W)) dut_i (.*);

  function automatic int model_addr();
    int lo;
    lo = m_lin ? ((m_st + m_cnt) % 4) : (m_st ^ m_cnt);
    return (m_up * 4) + lo;
  endfunction

  task automatic check(input string tag);
    int exp;
    exp = model_addr();
    vectors++;
    if (int'(addr_o) != exp) begin
      misses++;
      $display("FAIL %s: addr_o=%h expected %h", tag, addr_o, exp[ADDR_W-1:0]);
    end
  endtask

  task automatic cyc(input bit cpu, input bit ctl, input bit en, input bit adv,
                     input bit lin, input int addr, input string tag);
    @(negedge clk_i);
    cpu_strobe_i = cpu; ctl_strobe_i = ctl; chip_en_i = en;
    adv_i = adv; lin_mode_i = lin; addr_i = addr[ADDR_W-1:0];
    @(posedge clk_i);
    if ((cpu && en) || ctl) begin
      m_up = int'(addr_i) / 4; m_st = int'(addr_i) % 4; m_cnt = 0; m_lin = lin;
    end else if (adv) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    #5;
    check(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: cycles exhausted expected run end");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #5 check("R1");
    @(negedge clk_i) rst_ni = 1'b1;

    cyc(1,0,1,0,0,'h12345,"R2");
    cyc(0,0,0,1,0,0,"R5");        // start 1 interleaved: 1,0,3,2
    cyc(0,0,0,1,0,0,"R5");
    cyc(0,0,0,1,0,0,"R5");
    cyc(0,0,0,1,0,'h7ffff,"R7");  // wrap back to start, R8 upper fixed
    cyc(0,0,0,0,0,'h3,"R9");
    cyc(1,0,0,0,0,'habcde,"R3");  // disabled cpu strobe ignored
    cyc(0,1,0,0,1,'h00006,"R4");  // ctl load without chip enable
    cyc(0,0,0,1,0,0,"R6");        // linear 2,3,0,1
    cyc(0,0,0,1,0,0,"R11");       // mode flip mid burst ignored
    cyc(0,0,0,1,1,0,"R6");
    cyc(0,0,0,1,0,0,"R7");
    cyc(1,1,1,0,0,'h55557,"R4");
    cyc(1,0,1,0,1,'h11110,"R10");
    cyc(0,1,1,0,0,'h22223,"R10");
    cyc(1,0,1,1,0,'h33331,"R10");
    cyc(0,0,0,1,1,0,"R8");

    for (int i = 0; i < 400; i++) begin
      bit c, t, e, a, l;
      int ad;
      string tg;
      c = ($urandom % 4) == 0; t = ($urandom % 5) == 0;
      e = $urandom % 2; a = $urandom % 2; l = $urandom % 2;
      ad = int'($urandom % (1 << ADDR_W));
      if ((c && e) || t) tg = "R10";
      else if (a) tg = m_lin ? "R6" : "R5";
      else tg = c ? "R3" : "R9";
      cyc(c, t, e, a, l, ad, tg);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule